// File: doc/BRIEF.md
# Asynchronous Serial Frame Transmitter with Parity

This block turns one parallel data word per request into an asynchronous serial frame: a low start bit, the data bits least significant first, an optional parity bit and a high stop bit. A request pulse on `start_i` while the block is idle copies the complete frame into a single shift register at once. The register holds all ones when idle, so the serial line rests high.

The shift register advances only on clock cycles where the one-cycle `tick_i` strobe is high. `tick_i` comes from a bit-rate generator outside this block. `busy_o` stays high for the whole frame. It drops on the tick that ends the stop bit. The parity bit is either the even or the odd parity of the word, chosen by a parameter. A second parameter removes the parity bit from the frame.

The word is captured when the request is accepted. After that the data input has no effect on the frame in progress.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset, and whenever `busy_o` is low, `txd_o` is 1 and `busy_o` is 0.
- R2: A request (`start_i` = 1) seen while idle makes `busy_o` 1 and `txd_o` 0 (start bit) from the next cycle on.
- R3: Each tick while busy advances the line by one bit position. The DATA_W data bits follow the start bit, bit 0 first.
- R4: With PAR_EN = 1, the bit after the last data bit is the parity bit. It is the XOR of all data bits when PAR_TYPE = 0 (even) and the inverse of that XOR when PAR_TYPE = 1 (odd).
- R5: With PAR_EN = 0, the stop bit follows the last data bit directly. A frame is then DATA_W + 2 bit periods long.
- R6: The stop bit is 1. `busy_o` falls on the tick that ends the stop bit, so a frame lasts exactly DATA_W + PAR_EN + 2 ticks. `busy_o` never falls without a tick.
- R7: `txd_o` changes only on cycles after a tick while busy. Ticks while idle leave `txd_o` at 1 and `busy_o` at 0.
- R8: `start_i` is ignored while busy. The frame in progress, including its data and parity bits, is not changed.
- R9: A tick in the same cycle as an accepted request does not advance the new frame, so the start bit lasts a full tick period.
- R10: Asserting `rst_ni` low in the middle of a frame returns the block to idle at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to send `data_i`; accepted only while idle |
| data_i | input | DATA_W | Word to send |
| tick_i | input | 1 | One-cycle bit-rate strobe |
| txd_o | output | 1 | Serial line, idles high |
| busy_o | output | 1 | High while a frame is being sent |

## Verification
The assertions check four things on every cycle. The line is high whenever the block is idle. An accepted request brings up busy and the start bit on the next cycle. Without a tick, neither the line nor busy moves, including when a request arrives during a frame. A counter of ticks confirms that busy falls only after the full frame length. The order of the bits on the line, the parity value for both parity types, the frame without parity, a request and a tick arriving together, and a reset in the middle of a frame are shown only by the bench's scenarios. The bench compares every bit period against a frame it builds from the word itself.

// File: rtl/utx_pkg.sv
package utx_pkg;
  typedef enum logic {TX_IDLE, TX_SEND} tx_state_e;
  localparam bit PAR_EVEN = 1'b0;
  localparam bit PAR_ODD  = 1'b1;
endpackage

// File: rtl/utx_parity.sv
module utx_parity #(
  parameter int unsigned DATA_W   = 8,
  parameter bit          PAR_TYPE = utx_pkg::PAR_EVEN
) (
  input  logic [DATA_W-1:0] data_i,
  output logic              par_o
);
  if (PAR_TYPE == utx_pkg::PAR_ODD) begin : g_odd
    assign par_o = ~^data_i;
  end else begin : g_even
    assign par_o = ^data_i;
  end
endmodule

// File: rtl/utx_shifter.sv
module utx_shifter #(
  parameter int unsigned FRAME_W = 11
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic               shift_i,
  output logic               ser_o
);
  logic [FRAME_W-1:0] sreg_q;

  // idle content is all ones; ones fill in behind the stop bit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sreg_q <= '1;
    else if (load_i)  sreg_q <= frame_i;
    else if (shift_i) sreg_q <= {1'b1, sreg_q[FRAME_W-1:1]};
  end

  assign ser_o = sreg_q[0];
endmodule

// File: rtl/utx_seq.sv
module utx_seq #(
  parameter int unsigned N_BITS = 11
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic tick_i,
  output logic load_o,
  output logic shift_o,
  output logic busy_o
);
  import utx_pkg::*;
  localparam int unsigned CW = $clog2(N_BITS + 1);

  tx_state_e      state_q;
  logic [CW-1:0]  cnt_q;

  assign busy_o  = (state_q == TX_SEND);
  assign load_o  = (state_q == TX_IDLE) && start_i;
  assign shift_o = busy_o && tick_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TX_IDLE;
      cnt_q   <= '0;
    end else if (load_o) begin
      state_q <= TX_SEND;
      cnt_q   <= '0;
    end else if (shift_o) begin
      // last tick ends the stop bit period
      if (cnt_q == CW'(N_BITS - 1)) begin
        state_q <= TX_IDLE;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx #(
  parameter int unsigned DATA_W   = 8,
  parameter bit          PAR_EN   = 1'b1,
  parameter bit          PAR_TYPE = utx_pkg::PAR_EVEN
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              tick_i,
  output logic              txd_o,
  output logic              busy_o
);
  localparam int unsigned NB = DATA_W + int'(PAR_EN) + 2;

  logic [NB-1:0] frame;
  logic          load, shift;

  if (PAR_EN) begin : g_par
    logic par;
    utx_parity #(.DATA_W(DATA_W), .PAR_TYPE(PAR_TYPE)) u_par (
      .data_i(data_i), .par_o(par)
    );
    assign frame = {1'b1, par, data_i, 1'b0};
  end else begin : g_nopar
    assign frame = {1'b1, data_i, 1'b0};
  end

  utx_seq #(.N_BITS(NB)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .tick_i(tick_i),
    .load_o(load), .shift_o(shift), .busy_o(busy_o)
  );

  utx_shifter #(.FRAME_W(NB)) u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .frame_i(frame),
    .shift_i(shift), .ser_o(txd_o)
  );
endmodule

// File: rtl/utx_checker.sv
module utx_checker #(
  parameter int unsigned NB = 11
) (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic tick_i,
  input logic txd_o,
  input logic busy_o
);
  localparam int unsigned CW = $clog2(NB + 2);
  logic [CW-1:0] tick_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     tick_cnt <= '0;
    else if (!busy_o) tick_cnt <= '0;
    else if (tick_i)  tick_cnt <= tick_cnt + 1'b1;
  end

  a_r1_idle_line_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> txd_o);

  a_r2_start_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> (busy_o && !txd_o));

  a_r7_hold_without_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !tick_i) |=> (busy_o && $stable(txd_o)));

  a_r8_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !tick_i) |=> $stable(txd_o));

  a_r6_frame_length: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (tick_cnt == CW'(NB)));
endmodule

bind uart_frame_tx utx_checker #(.NB(NB)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .tick_i(tick_i),
  .txd_o(txd_o), .busy_o(busy_o)
);

// File: tb/uart_frame_tx_bench.sv
module uart_frame_tx_bench;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start = 1'b0, tick = 1'b0;
  logic [7:0] data = '0;
  logic [2:0] txd, busy;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // duts: 0 even parity, 1 odd parity, 2 no parity
  localparam int NBV [3] = '{11, 11, 10};
  localparam bit PEV [3] = '{1'b1, 1'b1, 1'b0};
  localparam bit PTV [3] = '{1'b0, 1'b1, 1'b0};

  always #2.5 clk = ~clk;

  uart_frame_tx u_uart_frame_tx (.clk_i(clk), .rst_ni(rst_ni), .start_i(start),
    .data_i(data), .tick_i(tick), .txd_o(txd[0]), .busy_o(busy[0]));
  uart_frame_tx #(.PAR_TYPE(1'b1)) u_uart_frame_tx_odd (.clk_i(clk), .rst_ni(rst_ni),
    .start_i(start), .data_i(data), .tick_i(tick), .txd_o(txd[1]), .busy_o(busy[1]));
  uart_frame_tx #(.PAR_EN(1'b0)) u_uart_frame_tx_np (.clk_i(clk), .rst_ni(rst_ni),
    .start_i(start), .data_i(data), .tick_i(tick), .txd_o(txd[2]), .busy_o(busy[2]));

  localparam logic [7:0] VDATA [6] = '{8'hA5, 8'h00, 8'hFF, 8'h01, 8'h80, 8'h6C};
  localparam int         VGAP  [6] = '{1, 3, 2, 4, 1, 5};

  function automatic logic exp_bit(logic [7:0] d, int k, bit pe, bit pt);
    if (k == 0) return 1'b0;
    if (k <= 8) return d[k-1];
    if (pe && k == 9) return (^d) ^ pt;
    return 1'b1;
  endfunction

  function automatic string tag_of(int k, bit pe);
    if (k == 0) return "R2";
    if (k <= 8) return "R3";
    if (k == 9) return pe ? "R4" : "R5";
    return "R6";
  endfunction

  task automatic chk(string req, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic chk_idle(string req);
    for (int i = 0; i < 3; i++) begin
      chk(req, "idle txd", txd[i], 1'b1);
      chk(req, "idle busy", busy[i], 1'b0);
    end
  endtask

  // hit: slot index before which a second request is injected (0 = none)
  task automatic run_frame(logic [7:0] d, int gap, int hit, bit with_tick);
    @(negedge clk); data = d; start = 1'b1; tick = with_tick;
    @(negedge clk); start = 1'b0; tick = 1'b0;
    for (int i = 0; i < 3; i++) begin
      chk(with_tick ? "R9" : "R2", "start bit", txd[i], 1'b0);
      chk(with_tick ? "R9" : "R2", "busy up", busy[i], 1'b1);
    end
    for (int k = 1; k <= 12; k++) begin
      if (k == hit) begin
        data = ~d; start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int i = 0; i < 3; i++) begin
          chk("R8", "line after ignored start", txd[i], exp_bit(d, k-1, PEV[i], PTV[i]));
          chk("R8", "busy after ignored start", busy[i], 1'b1);
        end
      end
      repeat (gap - 1) @(negedge clk);
      if (gap > 1)
        for (int i = 0; i < 3; i++)
          if (k <= NBV[i])
            chk("R7", "hold between ticks", txd[i], exp_bit(d, k-1, PEV[i], PTV[i]));
      tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      for (int i = 0; i < 3; i++) begin
        chk(tag_of(k, PEV[i]), "slot", txd[i], exp_bit(d, k, PEV[i], PTV[i]));
        chk("R6", "busy", busy[i], logic'(k < NBV[i]));
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_idle("R1");
    rst_ni = 1'b1;
    @(negedge clk);
    chk_idle("R1");

    for (int v = 0; v < 6; v++) run_frame(VDATA[v], VGAP[v], 0, 1'b0);

    // idle ticks: no effect (R7)
    repeat (4) begin tick = 1'b1; @(negedge clk); tick = 1'b0; @(negedge clk); end
    chk_idle("R7");

    // second request mid-frame (R8)
    run_frame(8'h3C, 2, 4, 1'b0);
    run_frame(8'hC3, 1, 10, 1'b0);

    // request and tick together (R9)
    run_frame(8'h5A, 3, 0, 1'b1);

    // reset mid-frame (R10)
    @(negedge clk); data = 8'h00; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (2) begin tick = 1'b1; @(negedge clk); tick = 1'b0; end
    rst_ni = 1'b0;
    #1;
    chk_idle("R10");
    @(negedge clk); rst_ni = 1'b1;
    @(negedge clk);
    chk_idle("R10");
    run_frame(8'h96, 2, 0, 1'b0);

    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule